// File: doc/BRIEF.md
# Complex Rotate-Multiply-Accumulate Instruction Decoder

This block looks at one 32-bit vector instruction word each clock. It picks out the complex arithmetic group: the complex multiply-accumulate with a rotation of 0, 90, 180 or 270 degrees, and the complex add with a rotation of 90 or 270 degrees. It accepts these in a three-register vector form and in an indexed-element form. For every word it reports one of three results. The word is outside the group. The word is in the group but its encoding is unallocated. The word is a legal operation, and then the block also gives the rotation, the element precision, the register numbers, the element index and the operation width in bytes.

Two enable inputs make operations legal or illegal. One enables complex arithmetic and the other enables half precision. The results are registered, so they appear one clock after the word is presented. The block sits in the decode stage next to the main opcode decoder. It has no effect on any other opcode.

Top module: `cmx_dec`

## Requirements
- R1: Three-register form. A word belongs to this form when bit 31=0, bits 28:24=01110, bit 21=0, bit 15=1, bit 10=1 and U (bit 29)=1. Its opcode is bits 14:11. Opcodes 8, 9, 10 and 11 are the complex multiply-accumulate, with is_add_o=0 and rot_o equal to opcode bits 1:0 (code 0/1/2/3 stands for 0/90/180/270 degrees). The register fields are Rm at bits 20:16, Rn at bits 9:5 and Rd at bits 4:0.
- R2: Three-register form. Opcodes 12 and 14 are the complex add, with is_add_o=1 and rot_o=1 (90 degrees) and 3 (270 degrees). Opcodes 13 and 15, any other opcode, U=0, and any mismatch in the fixed bits leave the word outside the group.
- R3: Three-register form. Size (bits 23:22) equal to 1, 2 or 3 gives prec_o half (1), single (2) or double (3). Size 0 is unallocated, and so is size 3 when Q (bit 30) is 0. idx_o is 0 in this form.
- R4: Indexed form. A word belongs to this form when bit 31=0, bits 28:24=01111 and bit 10=0. Its key is 16*U plus the opcode at bits 15:12, and the key must be 0x11, 0x13, 0x15 or 0x17. rot_o is taken from bits 14:13, indexed_o=1 and is_add_o=0.
- R5: Indexed form. Each indexed element is a real/imaginary pair. Size 1 means pairs of halves (prec_o=1) with idx_o={H,L}. Size 2 means pairs of singles (prec_o=2) with idx_o={0,H}. H is bit 11, L is bit 21 and rm_o is {bit 20, bits 19:16}. Sizes 0 and 3 are unallocated.
- R6: Indexed form. A pair of halves with H=1 and Q=0 is unallocated.
- R7: Every word in the group is unallocated while cmplx_en_i is 0.
- R8: Every half-precision word in either form is unallocated while fp16_en_i is 0.
- R9: A legal word gives rd_o from bits 4:0, rn_o from bits 9:5, and bytes_o equal to 16 when Q=1 and 8 when Q=0.
- R10: An unallocated word gives hit_o=1, unalloc_o=1 and valid_o=0, with every other output at 0. A word outside the group drives every output to 0.
- R11: Outputs follow the word one clock later. While the synchronous active-high reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| cmplx_en_i | input | 1 | Complex arithmetic enabled |
| fp16_en_i | input | 1 | Half precision enabled |
| hit_o | output | 1 | Word is in the complex group |
| valid_o | output | 1 | Legal complex operation |
| unalloc_o | output | 1 | In group but unallocated |
| is_add_o | output | 1 | Complex add (else multiply-accumulate) |
| indexed_o | output | 1 | Indexed-element form |
| rot_o | output | 2 | Rotation code, 90 degrees per step |
| prec_o | output | 2 | Element precision: 1 half, 2 single, 3 double |
| rd_o | output | 5 | Destination register |
| rn_o | output | 5 | First source register |
| rm_o | output | 5 | Second source register |
| idx_o | output | 2 | Element index (indexed form) |
| bytes_o | output | 5 | Operation width in bytes |

## Verification
The stimulus sweeps both forms. It covers every opcode, every size, U, Q, the H bit (or, in the three-register form, the fixed bit 21) and all four settings of the enable pair, with random register and L/M fields. Varying the opcode and U separates the members of the group from their neighbours. Varying size against Q and H exercises each legality rule alone and in combination with the others. Toggling the enables shows that each one gates exactly the operations it should. Random words with bit 31 set, and random words in general, confirm that no stray encoding reaches the group.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int IDX_W  = 2;
  localparam int LEN_W  = 5;
  localparam int ROT_W  = 2;
  localparam int PREC_W = 2;

  localparam logic [PREC_W-1:0] PREC_HALF = 2'd1;

  typedef struct packed {
    logic              hit;
    logic              bad;
    logic              is_add;
    logic [ROT_W-1:0]  rot;
    logic [PREC_W-1:0] prec;
    logic [REG_W-1:0]  rm;
    logic [IDX_W-1:0]  idx;
  } raw_t;
endpackage

// File: rtl/cmx_vec_dec.sv
module cmx_vec_dec
  import cmx_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              cmplx_en,
  input  logic              fp16_en,
  output raw_t              raw
);
  logic [3:0] opc;
  logic [1:0] sz;
  logic       q, shape, is_mla, is_add;

  always_comb begin
    opc    = insn[14:11];
    sz     = insn[23:22];
    q      = insn[30];
    shape  = !insn[31] && (insn[28:24] == 5'b01110) && !insn[21]
             && insn[15] && insn[10] && insn[29];
    is_mla = (opc[3:2] == 2'b10);
    is_add = (opc == 4'hC) || (opc == 4'hE);

    raw        = '0;
    raw.hit    = shape && (is_mla || is_add);
    raw.is_add = is_add;
    raw.rot    = is_mla ? opc[1:0] : {opc[1], 1'b1};
    raw.prec   = sz;
    raw.rm     = insn[20:16];
    raw.bad    = !cmplx_en || (sz == 2'd0) || (sz == 2'd1 && !fp16_en)
                 || (sz == 2'd3 && !q);
  end
endmodule

// File: rtl/cmx_elem_dec.sv
module cmx_elem_dec
  import cmx_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              cmplx_en,
  input  logic              fp16_en,
  output raw_t              raw
);
  logic [3:0] opc;
  logic [1:0] sz;
  logic       q, h, l, shape, pair_half, pair_single;

  always_comb begin
    opc         = insn[15:12];
    sz          = insn[23:22];
    q           = insn[30];
    h           = insn[11];
    l           = insn[21];
    shape       = !insn[31] && (insn[28:24] == 5'b01111) && !insn[10];
    pair_half   = (sz == 2'd1);
    pair_single = (sz == 2'd2);

    raw        = '0;
    raw.hit    = shape && insn[29] && !opc[3] && opc[0];
    raw.is_add = 1'b0;
    raw.rot    = insn[14:13];
    raw.prec   = sz;
    raw.rm     = {insn[20], insn[19:16]};
    raw.idx    = pair_half ? {h, l} : {1'b0, h};
    raw.bad    = !cmplx_en || !(pair_half || pair_single)
                 || (pair_half && h && !q) || (pair_half && !fp16_en);
  end
endmodule

// File: rtl/cmx_dec.sv
module cmx_dec
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       insn_i,
  input  logic              cmplx_en_i,
  input  logic              fp16_en_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic              unalloc_o,
  output logic              is_add_o,
  output logic              indexed_o,
  output logic [1:0]        rot_o,
  output logic [1:0]        prec_o,
  output logic [4:0]        rd_o,
  output logic [4:0]        rn_o,
  output logic [4:0]        rm_o,
  output logic [1:0]        idx_o,
  output logic [4:0]        bytes_o
);
  localparam logic [LEN_W-1:0] BYTES_Q  = LEN_W'(16);
  localparam logic [LEN_W-1:0] BYTES_NQ = LEN_W'(8);

  raw_t vec_raw, elem_raw, sel;
  logic sel_idx;

  cmx_vec_dec u_vec (
    .insn(insn_i), .cmplx_en(cmplx_en_i), .fp16_en(fp16_en_i), .raw(vec_raw)
  );

  cmx_elem_dec u_elem (
    .insn(insn_i), .cmplx_en(cmplx_en_i), .fp16_en(fp16_en_i), .raw(elem_raw)
  );

  always_comb begin
    sel_idx = elem_raw.hit;
    sel     = sel_idx ? elem_raw : vec_raw;
  end

  always_ff @(posedge clk) begin
    if (rst || !sel.hit || sel.bad) begin
      valid_o   <= 1'b0;
      is_add_o  <= 1'b0;
      indexed_o <= 1'b0;
      rot_o     <= '0;
      prec_o    <= '0;
      rd_o      <= '0;
      rn_o      <= '0;
      rm_o      <= '0;
      idx_o     <= '0;
      bytes_o   <= '0;
      hit_o     <= !rst && sel.hit;
      unalloc_o <= !rst && sel.hit;
    end else begin
      hit_o     <= 1'b1;
      unalloc_o <= 1'b0;
      valid_o   <= 1'b1;
      is_add_o  <= sel.is_add;
      indexed_o <= sel_idx;
      rot_o     <= sel.rot;
      prec_o    <= sel.prec;
      rd_o      <= insn_i[4:0];
      rn_o      <= insn_i[9:5];
      rm_o      <= sel.rm;
      idx_o     <= sel.idx;
      bytes_o   <= insn_i[30] ? BYTES_Q : BYTES_NQ;
    end
  end

  // R10: unallocated and legal are exclusive, and both need a hit
  p_unalloc_excl_r10: assert property (@(posedge clk) disable iff (rst)
    (unalloc_o |-> (!valid_o && hit_o)) and (valid_o |-> hit_o));

  // R10: unallocated result carries no operand fields
  p_unalloc_zero_r10: assert property (@(posedge clk) disable iff (rst)
    unalloc_o |-> (rd_o == '0 && rn_o == '0 && bytes_o == '0 && rot_o == '0));

  // R7: nothing legal while complex arithmetic is off
  p_cmplx_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(cmplx_en_i) |-> !valid_o);

  // R8: half precision needs its enable
  p_half_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && prec_o == PREC_HALF) |-> $past(fp16_en_i));

  // R9: width follows the quad bit of the word one clock earlier
  p_bytes_r9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (bytes_o == ($past(insn_i[30]) ? BYTES_Q : BYTES_NQ)));

  // R9: destination comes straight from the word
  p_rd_r9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (rd_o == $past(insn_i[4:0]) && rn_o == $past(insn_i[9:5])));

  // R6: half pairs with H set and Q clear are never legal
  p_idx_half_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && indexed_o && prec_o == PREC_HALF) |->
      !($past(insn_i[11]) && !$past(insn_i[30])));
endmodule

// File: tb/cmx_dec_tb.sv
module cmx_dec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] insn = '0;
  logic cmplx_en = 1'b0, fp16_en = 1'b0;
  logic hit, valid, unalloc, is_add, indexed;
  logic [1:0] rot, prec, idx;
  logic [4:0] rd, rn, rm, nbytes;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmx_dec u_dut (
    .clk(clk), .rst(rst), .insn_i(insn), .cmplx_en_i(cmplx_en),
    .fp16_en_i(fp16_en), .hit_o(hit), .valid_o(valid), .unalloc_o(unalloc),
    .is_add_o(is_add), .indexed_o(indexed), .rot_o(rot), .prec_o(prec),
    .rd_o(rd), .rn_o(rn), .rm_o(rm), .idx_o(idx), .bytes_o(nbytes)
  );

  typedef struct packed {
    logic       hit, valid, unalloc, is_add, indexed;
    logic [1:0] rot, prec;
    logic [4:0] rd, rn, rm;
    logic [1:0] idx;
    logic [4:0] nb;
  } exp_t;

  typedef struct {
    exp_t  e;
    string tag;
  } item_t;

  item_t sb[$];

  function automatic item_t model(input logic [31:0] w, input logic ce, input logic he);
    item_t it;
    logic q, u;
    logic [1:0] sz;
    logic [3:0] op;
    it.e = '0;
    it.tag = "R2";
    q  = w[30];
    u  = w[29];
    sz = w[23:22];
    if (!w[31] && w[28:24] == 5'b01110 && !w[21] && w[15] && w[10] && u) begin
      op = w[14:11];
      case (op)
        4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hE: begin
          it.e.hit = 1'b1;
          it.tag = (op >= 4'hC) ? "R2" : "R1";
          if (!ce) begin it.e.unalloc = 1'b1; it.tag = "R7"; end
          else if (sz == 2'd0 || (sz == 2'd3 && !q)) begin it.e.unalloc = 1'b1; it.tag = "R3"; end
          else if (sz == 2'd1 && !he) begin it.e.unalloc = 1'b1; it.tag = "R8"; end
          else begin
            it.e.valid  = 1'b1;
            it.e.is_add = (op >= 4'hC);
            case (op)
              4'hC: it.e.rot = 2'd1;
              4'hE: it.e.rot = 2'd3;
              default: it.e.rot = op[1:0];
            endcase
            it.e.prec = sz;
            it.e.rm = w[20:16];
            if (sz == 2'd3) it.tag = "R3";
          end
        end
        default: it.tag = "R2";
      endcase
    end else if (!w[31] && w[28:24] == 5'b01111 && !w[10]) begin
      op = w[15:12];
      it.tag = "R4";
      if ((16 * u + op) inside {5'h11, 5'h13, 5'h15, 5'h17}) begin
        it.e.hit = 1'b1;
        if (!ce) begin it.e.unalloc = 1'b1; it.tag = "R7"; end
        else if (sz != 2'd1 && sz != 2'd2) begin it.e.unalloc = 1'b1; it.tag = "R5"; end
        else if (sz == 2'd1 && w[11] && !q) begin it.e.unalloc = 1'b1; it.tag = "R6"; end
        else if (sz == 2'd1 && !he) begin it.e.unalloc = 1'b1; it.tag = "R8"; end
        else begin
          it.e.valid   = 1'b1;
          it.e.indexed = 1'b1;
          it.e.rot     = w[14:13];
          it.e.prec    = sz;
          it.e.rm      = {w[20], w[19:16]};
          it.e.idx     = (sz == 2'd1) ? {w[11], w[21]} : {1'b0, w[11]};
          it.tag       = "R5";
        end
      end
    end
    if (it.e.valid) begin
      it.e.rd = w[4:0];
      it.e.rn = w[9:5];
      it.e.nb = q ? 5'd16 : 5'd8;
    end
    if (it.e.unalloc) it.tag = {it.tag, "/R10"};
    return it;
  endfunction

  task automatic drive(input logic [31:0] w, input logic ce, input logic he);
    @(negedge clk);
    insn = w;
    cmplx_en = ce;
    fp16_en = he;
    sb.push_back(model(w, ce, he));
  endtask

  // Monitor: a result appears one clock after its word (R11)
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      exp_t got;
      it = sb.pop_front();
      got = '{hit, valid, unalloc, is_add, indexed, rot, prec, rd, rn, rm, idx, nbytes};
      checks++;
      if (got !== it.e) begin
        errors++;
        $display("FAIL %s insn got=%h exp=%h", it.tag, got, it.e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({hit, valid, unalloc, rd, nbytes} !== '0) begin
      errors++;
      $display("FAIL R11 reset got=%h exp=0", {hit, valid, unalloc, rd, nbytes});
    end
    @(negedge clk);
    rst = 1'b0;
    for (int form = 0; form < 2; form++)
      for (int op = 0; op < 16; op++)
        for (int u = 0; u < 2; u++)
          for (int sz = 0; sz < 4; sz++)
            for (int q = 0; q < 2; q++)
              for (int x = 0; x < 2; x++)
                for (int en = 0; en < 4; en++) begin
                  logic [31:0] w;
                  w = $urandom();
                  w[31] = 1'b0;
                  w[30] = q[0];
                  w[29] = u[0];
                  w[23:22] = sz[1:0];
                  if (form == 0) begin
                    w[28:24] = 5'b01110;
                    w[21] = x[0];
                    w[15] = 1'b1;
                    w[14:11] = op[3:0];
                    w[10] = 1'b1;
                  end else begin
                    w[28:24] = 5'b01111;
                    w[15:12] = op[3:0];
                    w[11] = x[0];
                    w[10] = 1'b0;
                  end
                  drive(w, en[1], en[0]);
                end
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      w = $urandom();
      if (k < 100) w[31] = 1'b1;
      drive(w, 1'b1, 1'b1);
    end
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 60000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog got=hung exp=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule